// File: doc/BRIEF.md
# Stack Push/Pop Sequencer

This block carries out the stack side of register save and restore for a CPU with 20-bit registers and addresses. One start pulse launches a push of one or more registers, a pop of one or more registers (or a pop of one value into a memory location relative to the stack), or the stack half of a subroutine call. The sequencer then walks through the registers, issuing one memory access per cycle. On each access it updates the stack pointer through a dedicated port, and it writes popped values through the register-file write port.

The ordering inside each step is the point of the block. A push takes its source value before the stack pointer moves. A pop moves the stack pointer before the destination is resolved. A call takes its jump target before the return address is stacked. Each step uses 2 bytes of stack in word width and 4 bytes in wide (20-bit) width. Every memory address the block issues has bit 0 cleared.

Top module: `stack_seq`

## Requirements
- R1: A push (op code 0) writes the source value at address SP-2 in word width or SP-4 in wide width, and leaves SP at that new value. In word width only the low 16 bits of the value are stored.
- R2: Pushing register 1 (SP) stores the SP value from before that push step. Pushing register 0 (PC) stores the `next_pc` input.
- R3: A multi-register push stores `reg_cnt`+1 registers. It starts at `base_reg` and counts down, so `base_reg` lands at the highest address. It makes exactly one memory access per register, in consecutive cycles.
- R4: A pop (op code 1) reads the value at SP, advances SP by 2 (word width) or 4 (wide width), and writes the value to register `base_reg`. In word width the value is zero-extended to 20 bits.
- R5: A pop with `dst_mem`=1 pops one value and stores it at the incremented SP plus the sign-extended 16-bit `dst_ofs`.
- R6: A multi-register pop restores `reg_cnt`+1 slots, starting at `base_reg` and counting up. The slots for register 1 (SP) and register 3 (constant generator) are consumed, but neither register is written from them.
- R7: A pop into register 0 (PC) writes the popped value with bit 0 cleared.
- R8: A call (op code 2) stores `next_pc` at SP-step and leaves SP there. It writes register 0 with the value register `base_reg` held before the push. When `base_reg` is SP, that value is the SP from before the decrement.
- R9: Every memory access uses an address with bit 0 cleared, even when SP is odd.
- R10: `done` is a one-cycle pulse in the cycle after the final access. Op code 3 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch an operation (accepted when idle) |
| op | input | 2 | 0 push, 1 pop, 2 call, 3 none |
| base_reg | input | 4 | First register index (or call target register) |
| reg_cnt | input | 4 | Number of registers minus one |
| wide | input | 1 | 1 = 20-bit width (4-byte slots), 0 = word width |
| next_pc | input | 20 | Address of the following instruction |
| dst_mem | input | 1 | Pop into memory instead of a register |
| dst_ofs | input | 16 | Signed offset from the incremented SP for a memory pop |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 20 | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 20 | Register-file write data |
| sp_in | input | 20 | Current stack pointer |
| sp_we | output | 1 | Stack pointer update enable |
| sp_wdata | output | 20 | New stack pointer |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | Access is 4 bytes (else 2) |
| mem_addr | output | 20 | Even byte address |
| mem_wdata | output | 20 | Write data |
| mem_rdata | input | 20 | Read data (same cycle) |
| done | output | 1 | Operation finished |

## Verification
A start pulse sampled at one clock edge produces the first memory access in the following cycle. After that, one access follows per cycle, and register, SP and memory writes take effect at the edge that closes each access. The `done` output rises one cycle after the last access. The bench drives at the falling edge and counts the accesses it sees until `done`. It checks register, SP and memory contents only once `done` is seen, when every write has landed. It also checks that `done` has dropped one cycle later.

// File: rtl/stk_pkg.sv
package stk_pkg;
   typedef enum logic [1:0] {
      OP_PUSH = 2'd0,
      OP_POP  = 2'd1,
      OP_CALL = 2'd2,
      OP_NONE = 2'd3
   } stk_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PUSH,
      S_POP,
      S_POPST,
      S_CALL
   } stk_state_e;
endpackage

// File: rtl/stk_sp_step.sv
module stk_sp_step #(
   parameter int AW = 20
) (
   input  logic [AW-1:0] sp,
   input  logic          wide,
   input  logic          dec,
   output logic [AW-1:0] sp_nx
);
   localparam logic [AW-1:0] STEP_W = AW'(2);
   localparam logic [AW-1:0] STEP_A = AW'(4);

   logic [AW-1:0] step;
   assign step  = wide ? STEP_A : STEP_W;
   assign sp_nx = dec ? (sp - step) : (sp + step);
endmodule

// File: rtl/stk_src_sel.sv
module stk_src_sel #(
   parameter int AW     = 20,
   parameter int RW     = 4,
   parameter int PC_IDX = 0,
   parameter int SP_IDX = 1
) (
   input  logic [RW-1:0] idx,
   input  logic [AW-1:0] rf_val,
   input  logic [AW-1:0] sp_cur,
   input  logic [AW-1:0] npc,
   input  logic          wide,
   output logic [AW-1:0] val
);
   localparam int WORD_W = 16;

   logic [AW-1:0] raw;
   always_comb begin
      if (idx == RW'(PC_IDX))      raw = npc;
      else if (idx == RW'(SP_IDX)) raw = sp_cur;
      else                         raw = rf_val;
   end

   generate
      if (AW > WORD_W) begin : g_mask
         assign val = wide ? raw : {{(AW-WORD_W){1'b0}}, raw[WORD_W-1:0]};
      end else begin : g_pass
         assign val = raw;
      end
   endgenerate
endmodule

// File: rtl/stk_dst_ctl.sv
module stk_dst_ctl #(
   parameter int AW     = 20,
   parameter int RW     = 4,
   parameter int PC_IDX = 0,
   parameter int SP_IDX = 1,
   parameter int CG_IDX = 3
) (
   input  logic [RW-1:0] idx,
   input  logic [AW-1:0] rdata,
   input  logic          wide,
   input  logic          multi,
   output logic [AW-1:0] val,
   output logic          reg_we,
   output logic [AW-1:0] reg_data,
   output logic          sp_take
);
   localparam int WORD_W = 16;

   logic is_pc, is_sp, is_cg;
   assign is_pc = (idx == RW'(PC_IDX));
   assign is_sp = (idx == RW'(SP_IDX));
   assign is_cg = (idx == RW'(CG_IDX));

   generate
      if (AW > WORD_W) begin : g_mask
         assign val = wide ? rdata : {{(AW-WORD_W){1'b0}}, rdata[WORD_W-1:0]};
      end else begin : g_pass
         assign val = rdata;
      end
   endgenerate

   assign reg_we   = !is_sp && !is_cg;
   assign reg_data = is_pc ? {val[AW-1:1], 1'b0} : val;
   assign sp_take  = is_sp && !multi;
endmodule

// File: rtl/stack_seq.sv
module stack_seq
   import stk_pkg::*;
#(
   parameter int AW     = 20,
   parameter int RW     = 4,
   parameter int OFS_W  = 16,
   parameter int PC_IDX = 0,
   parameter int SP_IDX = 1,
   parameter int CG_IDX = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    op,
   input  logic [RW-1:0] base_reg,
   input  logic [RW-1:0] reg_cnt,
   input  logic          wide,
   input  logic [AW-1:0] next_pc,
   input  logic          dst_mem,
   input  logic [OFS_W-1:0] dst_ofs,
   output logic [RW-1:0] rf_raddr,
   input  logic [AW-1:0] rf_rdata,
   output logic          rf_we,
   output logic [RW-1:0] rf_waddr,
   output logic [AW-1:0] rf_wdata,
   input  logic [AW-1:0] sp_in,
   output logic          sp_we,
   output logic [AW-1:0] sp_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_wide,
   output logic [AW-1:0] mem_addr,
   output logic [AW-1:0] mem_wdata,
   input  logic [AW-1:0] mem_rdata,
   output logic          done
);
   localparam int NREG = 1 << RW;

   generate
      if (AW <= OFS_W) begin : g_bad_ofs
         $error("stack_seq: AW must exceed OFS_W");
      end
      if (PC_IDX >= NREG || SP_IDX >= NREG || CG_IDX >= NREG) begin : g_bad_idx
         $error("stack_seq: special register index out of range");
      end
      if (PC_IDX == SP_IDX || SP_IDX == CG_IDX || PC_IDX == CG_IDX) begin : g_bad_dup
         $error("stack_seq: special register indices must differ");
      end
   endgenerate

   stk_state_e           state_q;
   logic [RW-1:0]        idx_q, left_q;
   logic                 wide_q, dmem_q, multi_q, done_q;
   logic [AW-1:0]        pc_q, sp_q, val_q;
   logic [OFS_W-1:0]     ofs_q;

   logic [AW-1:0] src_val, sp_nx, pop_val, pop_data, ofs_ext;
   logic          pop_we, sp_take, pop_reg;

   stk_src_sel #(.AW(AW), .RW(RW), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX)) u_src (
      .idx(idx_q), .rf_val(rf_rdata), .sp_cur(sp_q), .npc(pc_q),
      .wide(wide_q), .val(src_val)
   );

   stk_sp_step #(.AW(AW)) u_step (
      .sp(sp_q), .wide(wide_q), .dec(state_q != S_POP), .sp_nx(sp_nx)
   );

   stk_dst_ctl #(.AW(AW), .RW(RW), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX), .CG_IDX(CG_IDX)) u_dst (
      .idx(idx_q), .rdata(mem_rdata), .wide(wide_q), .multi(multi_q),
      .val(pop_val), .reg_we(pop_we), .reg_data(pop_data), .sp_take(sp_take)
   );

   assign ofs_ext  = {{(AW-OFS_W){ofs_q[OFS_W-1]}}, ofs_q};
   assign pop_reg  = (state_q == S_POP) && !dmem_q;
   assign rf_raddr = idx_q;
   assign mem_wide = wide_q;
   assign done     = done_q;

   logic [AW-1:0] addr_raw;
   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      addr_raw  = sp_q;
      mem_wdata = '0;
      sp_we     = 1'b0;
      sp_wdata  = sp_nx;
      rf_we     = 1'b0;
      rf_waddr  = idx_q;
      rf_wdata  = pop_data;
      unique case (state_q)
         S_PUSH: begin
            mem_req = 1'b1; mem_we = 1'b1; addr_raw = sp_nx;
            mem_wdata = src_val; sp_we = 1'b1;
         end
         S_CALL: begin
            mem_req = 1'b1; mem_we = 1'b1; addr_raw = sp_nx;
            mem_wdata = wide_q ? pc_q : {{(AW-16){1'b0}}, pc_q[15:0]};
            sp_we = 1'b1;
            rf_we = 1'b1; rf_waddr = RW'(PC_IDX);
            rf_wdata = {src_val[AW-1:1], 1'b0};
         end
         S_POP: begin
            mem_req = 1'b1; addr_raw = sp_q; sp_we = 1'b1;
            if (pop_reg && sp_take) sp_wdata = pop_val;
            rf_we = pop_reg && pop_we;
         end
         S_POPST: begin
            mem_req = 1'b1; mem_we = 1'b1; addr_raw = sp_q + ofs_ext;
            mem_wdata = val_q;
         end
         default: ;
      endcase
   end
   assign mem_addr = {addr_raw[AW-1:1], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         left_q  <= '0;
         wide_q  <= 1'b0;
         dmem_q  <= 1'b0;
         multi_q <= 1'b0;
         done_q  <= 1'b0;
         pc_q    <= '0;
         sp_q    <= '0;
         val_q   <= '0;
         ofs_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start && stk_op_e'(op) != OP_NONE) begin
                  idx_q   <= base_reg;
                  wide_q  <= wide;
                  pc_q    <= next_pc;
                  sp_q    <= sp_in;
                  ofs_q   <= dst_ofs;
                  dmem_q  <= (stk_op_e'(op) == OP_POP) && dst_mem;
                  multi_q <= (stk_op_e'(op) == OP_POP) && !dst_mem && (reg_cnt != '0);
                  left_q  <= (stk_op_e'(op) == OP_CALL ||
                              (stk_op_e'(op) == OP_POP && dst_mem)) ? '0 : reg_cnt;
                  unique case (stk_op_e'(op))
                     OP_PUSH: state_q <= S_PUSH;
                     OP_POP:  state_q <= S_POP;
                     default: state_q <= S_CALL;
                  endcase
               end
            end
            S_PUSH: begin
               sp_q  <= sp_nx;
               idx_q <= idx_q - 1'b1;
               if (left_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
            S_POP: begin
               sp_q  <= sp_wdata;
               val_q <= pop_val;
               idx_q <= idx_q + 1'b1;
               if (dmem_q) begin
                  state_q <= S_POPST;
               end else if (left_q == '0) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
            S_POPST: begin
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            S_CALL: begin
               sp_q    <= sp_nx;
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
   parameter int AW     = 20,
   parameter int RW     = 4,
   parameter int PC_IDX = 0,
   parameter int SP_IDX = 1,
   parameter int CG_IDX = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_wide,
   input logic [AW-1:0] mem_addr,
   input logic [AW-1:0] mem_wdata,
   input logic          sp_we,
   input logic [AW-1:0] sp_wdata,
   input logic          rf_we,
   input logic [RW-1:0] rf_waddr,
   input logic [AW-1:0] rf_wdata,
   input logic          done
);
   a_r9_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]);

   a_r1_store_at_new_sp: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && sp_we) |-> (mem_addr == {sp_wdata[AW-1:1], 1'b0}));

   a_r1_word_store_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_wide) |-> (mem_wdata[AW-1:16] == '0));

   a_r6_no_cg_sp_write: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_waddr != RW'(CG_IDX) && rf_waddr != RW'(SP_IDX)));

   a_r7_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && rf_waddr == RW'(PC_IDX)) |-> !rf_wdata[0]);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(mem_req));
endmodule

bind stack_seq stack_seq_chk #(
   .AW(AW), .RW(RW), .PC_IDX(PC_IDX), .SP_IDX(SP_IDX), .CG_IDX(CG_IDX)
) u_chk (.*);

// File: tb/stack_seq_bench.sv
`timescale 1ns/1ps
module stack_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd3;
   logic [3:0]  base_reg = '0, reg_cnt = '0;
   logic        wide = 1'b0, dst_mem = 1'b0;
   logic [19:0] next_pc = '0;
   logic [15:0] dst_ofs = '0;
   logic [3:0]  rf_raddr, rf_waddr;
   logic [19:0] rf_rdata, rf_wdata, sp_in, sp_wdata, mem_addr, mem_wdata, mem_rdata;
   logic        rf_we, sp_we, mem_req, mem_we, mem_wide, done;

   int checks = 0, errors = 0, odd_seen = 0;
   logic [19:0] rf [16];
   logic [7:0]  mem [1024];

   always #2.5 clk = ~clk;

   stack_seq u_stack_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_reg(base_reg),
      .reg_cnt(reg_cnt), .wide(wide), .next_pc(next_pc), .dst_mem(dst_mem),
      .dst_ofs(dst_ofs), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
      .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .sp_in(sp_in), .sp_we(sp_we),
      .sp_wdata(sp_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
   );

   assign rf_rdata = rf[rf_raddr];
   assign sp_in    = rf[1];

   always_comb begin
      logic [9:0] a;
      a = mem_addr[9:0];
      if (mem_wide) mem_rdata = {mem[a+10'd2][3:0], mem[a+10'd1], mem[a]};
      else          mem_rdata = {4'h0, mem[a+10'd1], mem[a]};
   end

   always @(posedge clk) begin
      if (mem_req && mem_addr[0]) odd_seen <= odd_seen + 1;
      if (mem_req && mem_we) begin
         mem[mem_addr[9:0]]        <= mem_wdata[7:0];
         mem[mem_addr[9:0]+10'd1]  <= mem_wdata[15:8];
         if (mem_wide) begin
            mem[mem_addr[9:0]+10'd2] <= {4'h0, mem_wdata[19:16]};
            mem[mem_addr[9:0]+10'd3] <= 8'h00;
         end
      end
      if (rf_we) rf[rf_waddr] <= rf_wdata;
      if (sp_we) rf[1] <= sp_wdata;
   end

   function automatic logic [19:0] rd16(input int a);
      return {4'h0, mem[a+1], mem[a]};
   endfunction
   function automatic logic [19:0] rd20(input int a);
      return {mem[a+2][3:0], mem[a+1], mem[a]};
   endfunction
   task automatic wr16(input int a, input logic [15:0] v);
      mem[a] = v[7:0]; mem[a+1] = v[15:8];
   endtask
   task automatic wr20(input int a, input logic [19:0] v);
      mem[a] = v[7:0]; mem[a+1] = v[15:8]; mem[a+2] = {4'h0, v[19:16]}; mem[a+3] = 8'h0;
   endtask

   task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Launch one operation; returns number of access cycles seen before done.
   task automatic run_op(input logic [1:0] o, input logic [3:0] b, input logic [3:0] c,
                         input logic w, input logic [19:0] npc, input logic dm,
                         input logic [15:0] ofs, output int acc);
      int guard;
      acc = 0; guard = 0;
      @(negedge clk);
      op = o; base_reg = b; reg_cnt = c; wide = w; next_pc = npc;
      dst_mem = dm; dst_ofs = ofs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && guard < 60) begin
         if (mem_req) acc++;
         guard++;
         @(negedge clk);
      end
      if (!done) check("R10 watchdog: done never rose", 20'h0, 20'h1);
      @(negedge clk);
      check("R10 done drops after one cycle", {19'h0, done}, 20'h0);
   endtask

   task automatic t_reset();
      check("R10 reset done", {19'h0, done}, 20'h0);
      check("R10 reset mem_req", {19'h0, mem_req}, 20'h0);
      check("R10 reset writes", {18'h0, rf_we, sp_we}, 20'h0);
   endtask

   task automatic t_push_word();
      int n;
      rf[1] = 20'h00400; rf[5] = 20'hF1234;
      run_op(2'd0, 4'd5, 4'd0, 1'b0, 20'h0, 1'b0, 16'h0, n);
      check("R1 push word data", rd16(20'h3FE), 20'h01234);
      check("R1 push word SP", rf[1], 20'h003FE);
      check("R1 push word one access", 20'(n), 20'd1);
   endtask

   task automatic t_push_wide();
      int n;
      rf[1] = 20'h00400; rf[6] = 20'hABCDE;
      run_op(2'd0, 4'd6, 4'd0, 1'b1, 20'h0, 1'b0, 16'h0, n);
      check("R1 push wide data", rd20(20'h3FC), 20'hABCDE);
      check("R1 push wide SP", rf[1], 20'h003FC);
   endtask

   task automatic t_push_sp_pc();
      int n;
      rf[1] = 20'h00400;
      run_op(2'd0, 4'd1, 4'd0, 1'b0, 20'h0, 1'b0, 16'h0, n);
      check("R2 push SP stores old SP", rd16(20'h3FE), 20'h00400);
      run_op(2'd0, 4'd0, 4'd0, 1'b1, 20'h12346, 1'b0, 16'h0, n);
      check("R2 push PC stores next_pc", rd20(20'h3FA), 20'h12346);
      check("R2 SP after two pushes", rf[1], 20'h003FA);
   endtask

   task automatic t_multi_push();
      int n;
      rf[1] = 20'h00400; rf[7] = 20'h00777; rf[6] = 20'h00666; rf[5] = 20'h00555;
      run_op(2'd0, 4'd7, 4'd2, 1'b0, 20'h0, 1'b0, 16'h0, n);
      check("R3 top slot holds base reg", rd16(20'h3FE), 20'h00777);
      check("R3 middle slot", rd16(20'h3FC), 20'h00666);
      check("R3 bottom slot", rd16(20'h3FA), 20'h00555);
      check("R3 SP after multi push", rf[1], 20'h003FA);
      check("R3 access count", 20'(n), 20'd3);
   endtask

   task automatic t_pop();
      int n;
      rf[1] = 20'h003F0; rf[9] = 20'hFFFFF; wr16(20'h3F0, 16'h8001);
      run_op(2'd1, 4'd9, 4'd0, 1'b0, 20'h0, 1'b0, 16'h0, n);
      check("R4 pop word zero-extends", rf[9], 20'h08001);
      check("R4 pop word SP", rf[1], 20'h003F2);
      rf[1] = 20'h003F0; wr20(20'h3F0, 20'h9ABCD);
      run_op(2'd1, 4'd10, 4'd0, 1'b1, 20'h0, 1'b0, 16'h0, n);
      check("R4 pop wide value", rf[10], 20'h9ABCD);
      check("R4 pop wide SP", rf[1], 20'h003F4);
   endtask

   task automatic t_pop_pc();
      int n;
      rf[1] = 20'h003F0; wr16(20'h3F0, 16'h4567);
      run_op(2'd1, 4'd0, 4'd0, 1'b0, 20'h0, 1'b0, 16'h0, n);
      check("R7 pop into PC clears bit 0", rf[0], 20'h04566);
   endtask

   task automatic t_multi_pop();
      int n;
      rf[1] = 20'h003E0; rf[3] = 20'h00CCC;
      wr16(20'h3E0, 16'h1111); wr16(20'h3E2, 16'h2222);
      wr16(20'h3E4, 16'h3333); wr16(20'h3E6, 16'h4444);
      run_op(2'd1, 4'd1, 4'd3, 1'b0, 20'h0, 1'b0, 16'h0, n);
      check("R6 R2 restored", rf[2], 20'h02222);
      check("R6 CG not written", rf[3], 20'h00CCC);
      check("R6 R4 restored", rf[4], 20'h04444);
      check("R6 SP skips stacked slot, all consumed", rf[1], 20'h003E8);
      check("R6 access count", 20'(n), 20'd4);
   endtask

   task automatic t_pop_mem();
      int n;
      rf[1] = 20'h003C0; wr16(20'h3C0, 16'h5555); wr16(20'h3C2, 16'h0000);
      run_op(2'd1, 4'd0, 4'd0, 1'b0, 20'h0, 1'b1, 16'h0000, n);
      check("R5 store at incremented SP", rd16(20'h3C2), 20'h05555);
      check("R5 SP after memory pop", rf[1], 20'h003C2);
      rf[1] = 20'h003C0; wr16(20'h3C0, 16'h6666);
      run_op(2'd1, 4'd0, 4'd0, 1'b0, 20'h0, 1'b1, 16'hFFFC, n);
      check("R5 negative offset", rd16(20'h3BE), 20'h06666);
   endtask

   task automatic t_call();
      int n;
      rf[1] = 20'h00400;
      run_op(2'd2, 4'd1, 4'd0, 1'b1, 20'h23456, 1'b0, 16'h0, n);
      check("R8 call via SP jumps to old SP", rf[0], 20'h00400);
      check("R8 return address stacked", rd20(20'h3FC), 20'h23456);
      check("R8 SP after call", rf[1], 20'h003FC);
      rf[1] = 20'h00400; rf[6] = 20'h00F00;
      run_op(2'd2, 4'd6, 4'd0, 1'b0, 20'h01234, 1'b0, 16'h0, n);
      check("R8 call via register", rf[0], 20'h00F00);
      check("R8 word return address", rd16(20'h3FE), 20'h01234);
   endtask

   task automatic t_odd_sp();
      int n;
      rf[1] = 20'h00401; rf[5] = 20'h0BEEF;
      run_op(2'd0, 4'd5, 4'd0, 1'b0, 20'h0, 1'b0, 16'h0, n);
      check("R9 odd SP store aligned", rd16(20'h3FE), 20'h0BEEF);
      check("R9 odd SP updated", rf[1], 20'h003FF);
   endtask

   task automatic t_nop();
      int seen;
      seen = 0;
      rf[1] = 20'h00300;
      @(negedge clk);
      op = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (mem_req || done || sp_we || rf_we) seen++;
         @(negedge clk);
      end
      check("R10 op 3 makes no activity", 20'(seen), 20'd0);
      check("R10 op 3 leaves SP", rf[1], 20'h00300);
   endtask

   initial begin
      #200000;
      check("R10 global watchdog", 20'h0, 20'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) rf[i] = '0;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_push_word();
      t_push_wide();
      t_push_sp_pc();
      t_multi_push();
      t_pop();
      t_pop_pc();
      t_multi_pop();
      t_pop_mem();
      t_call();
      t_odd_sp();
      t_nop();
      check("R9 no odd address issued", 20'(odd_seen), 20'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule